// File: doc/BRIEF.md
# Wiper Position Register Bank

This block keeps the position of a 256-tap digital potentiometer wiper. It also keeps a small set of preset positions next to it. A serial front end sends it one command at a time.

A command can do one of five things:
- write a code straight into the wiper register;
- write a code into one preset slot;
- copy a preset slot into the wiper;
- copy the wiper into a preset slot;
- move the wiper one step up or down.

A separate step strobe moves the wiper by one code in the direction that `step_up` selects. This strobe is meant to be derived from a gated serial clock.

The block drives out two things: the current wiper code, and a one-hot tap select for the resistor array. Code zero selects the low-terminal tap and the all-ones code selects the high-terminal tap.

The command port uses valid/ready. `cmd_ready` is high whenever the block is out of reset, so it never applies back-pressure. A command is taken on every rising edge where both `cmd_valid` and `cmd_ready` are high. Its effect is visible right after that edge. The sender may change its payload freely while `cmd_valid` is low.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, the wiper code and all preset slots are cleared to 0, and `cmd_ready` is low. After reset, `cmd_ready` is high.
- R2: An accepted command with `cmd_op`=0 writes `cmd_data` into the wiper in one clock.
- R3: An accepted command with `cmd_op`=1 writes `cmd_data` into the preset slot chosen by `cmd_idx` (0 to 3). The wiper is not changed.
- R4: An accepted command with `cmd_op`=2 copies the preset slot chosen by `cmd_idx` into the wiper in one clock.
- R5: An accepted command with `cmd_op`=3 copies the wiper into the preset slot chosen by `cmd_idx` in one clock. Other slots keep their values.
- R6: An accepted command with `cmd_op`=4 adds one to the wiper, and `cmd_op`=5 subtracts one. Adding at 255 leaves 255, and subtracting at 0 leaves 0.
- R7: A `step_pulse` cycle with no accepted command moves the wiper by one code: up when `step_up`=1, down when `step_up`=0. It saturates at 255 and at 0 in the same way as R6.
- R8: In a cycle where a command is accepted, `step_pulse` is ignored. Values 6 and 7 of `cmd_op` change nothing, and neither does any command presented while `cmd_valid` is low.
- R9: `tap_sel` has exactly one bit set, at the index equal to `wiper_code`. It changes on the same clock edge as `wiper_code`, so bit 0 marks the low tap and bit 255 marks the high tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken (high whenever out of reset) |
| cmd_op | input | 3 | Operation code (0 to 5 defined) |
| cmd_idx | input | 2 | Preset slot index |
| cmd_data | input | 8 | Code used by operations 0 and 1 |
| step_pulse | input | 1 | Single-step strobe |
| step_up | input | 1 | Step direction: 1 is up, 0 is down |
| wiper_code | output | 8 | Current wiper code |
| tap_sel | output | 256 | One-hot tap select |

## Verification
There is no read port for the preset slots, so slot contents are checked by copying a slot into the wiper and watching the wiper.

The tests use distinct values in each slot, so a copy that lands in the wrong slot, or one that also disturbs another slot, shows up as a wrong code.

Stepping is driven across both ends of the range, through commands and through the strobe. This separates saturation from wrap-around.

Some cycles present a command and a step at the same time. Others present undefined operation codes, or a valid-low command with a live payload. Together these show which input is allowed to move the wiper.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [2:0] {
    OP_SET_WIPER = 3'd0,
    OP_SET_SLOT  = 3'd1,
    OP_RECALL    = 3'd2,
    OP_STORE     = 3'd3,
    OP_UP        = 3'd4,
    OP_DOWN      = 3'd5
  } wb_op_e;
endpackage

// File: rtl/wb_slot_file.sv
module wb_slot_file #(
  parameter int CODE_W = 8,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [CODE_W-1:0]            wr_val,
  output logic [SLOTS-1:0][CODE_W-1:0] slots
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[s] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(s)))
        slots[s] <= wr_val;
    end
  end
endmodule

// File: rtl/wb_wiper_ctr.sv
module wb_wiper_ctr #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CODE_W-1:0] ld_val,
  input  logic              up,
  input  logic              down,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      code <= '0;
    else if (ld_en)
      code <= ld_val;
    else if (up && code != TOP)
      code <= code + 1'b1;
    else if (down && code != '0)
      code <= code - 1'b1;
  end
endmodule

// File: rtl/wb_tap_decode.sv
module wb_tap_decode #(
  parameter int CODE_W = 8,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [TAPS-1:0]   sel
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign sel[t] = (code == CODE_W'(t));
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int CODE_W = 8,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int TAPS  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [CODE_W-1:0] cmd_data,
  input  logic              step_pulse,
  input  logic              step_up,
  output logic [CODE_W-1:0] wiper_code,
  output logic [TAPS-1:0]   tap_sel
);
  import wb_pkg::*;

  logic                         take;
  logic                         ld_en, up, down, slot_we;
  logic [CODE_W-1:0]            ld_val, slot_wval;
  logic [SLOTS-1:0][CODE_W-1:0] slots;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  assign take = cmd_valid && cmd_ready;

  always_comb begin
    ld_en     = 1'b0;
    ld_val    = cmd_data;
    up        = 1'b0;
    down      = 1'b0;
    slot_we   = 1'b0;
    slot_wval = cmd_data;
    if (take) begin
      case (cmd_op)
        OP_SET_WIPER: ld_en = 1'b1;
        OP_SET_SLOT:  slot_we = 1'b1;
        OP_RECALL: begin
          ld_en  = 1'b1;
          ld_val = slots[cmd_idx];
        end
        OP_STORE: begin
          slot_we   = 1'b1;
          slot_wval = wiper_code;
        end
        OP_UP:   up   = 1'b1;
        OP_DOWN: down = 1'b1;
        default: ;
      endcase
    end else if (step_pulse) begin
      up   = step_up;
      down = !step_up;
    end
  end

  wb_slot_file #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(slot_we), .wr_idx(cmd_idx),
    .wr_val(slot_wval), .slots(slots)
  );

  wb_wiper_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
    .up(up), .down(down), .code(wiper_code)
  );

  wb_tap_decode #(.CODE_W(CODE_W)) u_dec (
    .code(wiper_code), .sel(tap_sel)
  );
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int CODE_W = 8,
  parameter int SLOTS  = 4,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int TAPS  = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [IDX_W-1:0]  cmd_idx,
  input logic [CODE_W-1:0] cmd_data,
  input logic              step_pulse,
  input logic              step_up,
  input logic [CODE_W-1:0] wiper_code,
  input logic [TAPS-1:0]   tap_sel
);
  localparam logic [CODE_W-1:0] TOP = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (wiper_code == '0 && !cmd_ready));

  // R2
  set_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0) |=> wiper_code == $past(cmd_data));

  // R6
  up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd4 && wiper_code == TOP) |=> wiper_code == TOP);

  // R6
  down_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd5 && wiper_code == '0) |=> wiper_code == '0);

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cmd_valid && cmd_ready) && step_pulse && step_up && wiper_code != TOP)
      |=> wiper_code == $past(wiper_code) + 1'b1);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid && !step_pulse) |=> $stable(wiper_code));

  // R9
  tap_onehot_chk: assert property (@(posedge clk)
    $countones(tap_sel) == 1 && tap_sel[wiper_code]);
endmodule

bind wiper_bank wiper_bank_chk #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_idx;
  logic [7:0]   cmd_data;
  logic         step_pulse;
  logic         step_up;
  logic [7:0]   wiper_code;
  logic [255:0] tap_sel;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  wiper_bank dut (.*);

  task automatic expect_code(input string req, input logic [7:0] exp);
    compared++;
    if (wiper_code !== exp) begin
      mismatched++;
      $display("FAIL %s: wiper_code=%0d expected %0d", req, wiper_code, exp);
    end
    compared++;
    if ($countones(tap_sel) != 1 || tap_sel[exp] !== 1'b1) begin
      mismatched++;
      $display("FAIL R9: tap_sel ones=%0d bit[%0d]=%b expected one-hot at %0d",
               $countones(tap_sel), exp, tap_sel[exp], exp);
    end
  endtask

  // Drive a command for one cycle, optionally with a step strobe in the same cycle.
  task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [7:0] d,
                       input logic v, input logic sp, input logic su);
    @(negedge clk);
    cmd_valid  = v;
    cmd_op     = op;
    cmd_idx    = idx;
    cmd_data   = d;
    step_pulse = sp;
    step_up    = su;
    @(negedge clk);
    cmd_valid  = 1'b0;
    step_pulse = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] idx, input logic [7:0] d);
    issue(op, idx, d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic step(input logic su);
    issue(3'd0, 2'd0, 8'h00, 1'b0, 1'b1, su);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_idx = '0; cmd_data = '0;
    step_pulse = 1'b0; step_up = 1'b0;
    repeat (3) @(negedge clk);
    compared++;
    if (cmd_ready !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: cmd_ready=%b expected 0 in reset", cmd_ready);
    end
    expect_code("R1", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    compared++;
    if (cmd_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R1: cmd_ready=%b expected 1", cmd_ready);
    end
    for (int s = 0; s < 4; s++) begin
      cmd(3'd0, 2'd0, 8'h5A);
      cmd(3'd2, 2'(s), 8'h00);
      expect_code("R1", 8'h00);
    end
  endtask

  task automatic t_set_wiper;
    cmd(3'd0, 2'd0, 8'h00); expect_code("R2", 8'h00);
    cmd(3'd0, 2'd0, 8'hFF); expect_code("R2", 8'hFF);
    cmd(3'd0, 2'd0, 8'h81); expect_code("R2", 8'h81);
  endtask

  task automatic t_slots;
    cmd(3'd0, 2'd0, 8'h44);
    cmd(3'd1, 2'd0, 8'h11);
    cmd(3'd1, 2'd1, 8'h22);
    cmd(3'd1, 2'd2, 8'h33);
    cmd(3'd1, 2'd3, 8'hEE);
    expect_code("R3", 8'h44);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] e;
      e = (s == 3) ? 8'hEE : 8'(8'h11 * (s + 1));
      cmd(3'd2, 2'(s), 8'h00);
      expect_code("R4", e);
    end
  endtask

  task automatic t_store;
    cmd(3'd0, 2'd0, 8'hC3);
    cmd(3'd3, 2'd2, 8'h00);
    cmd(3'd0, 2'd0, 8'h07);
    cmd(3'd2, 2'd2, 8'h00); expect_code("R5", 8'hC3);
    cmd(3'd2, 2'd1, 8'h00); expect_code("R5", 8'h22);
    cmd(3'd2, 2'd3, 8'h00); expect_code("R5", 8'hEE);
  endtask

  task automatic t_cmd_step;
    cmd(3'd0, 2'd0, 8'hFE);
    cmd(3'd4, 2'd0, 8'h00); expect_code("R6", 8'hFF);
    cmd(3'd4, 2'd0, 8'h00); expect_code("R6", 8'hFF);
    cmd(3'd5, 2'd0, 8'h00); expect_code("R6", 8'hFE);
    cmd(3'd0, 2'd0, 8'h01);
    cmd(3'd5, 2'd0, 8'h00); expect_code("R6", 8'h00);
    cmd(3'd5, 2'd0, 8'h00); expect_code("R6", 8'h00);
  endtask

  task automatic t_strobe;
    cmd(3'd0, 2'd0, 8'h7F);
    step(1'b1); expect_code("R7", 8'h80);
    step(1'b0); step(1'b0); expect_code("R7", 8'h7E);
    cmd(3'd0, 2'd0, 8'hFF);
    step(1'b1); expect_code("R7", 8'hFF);
    cmd(3'd0, 2'd0, 8'h00);
    step(1'b0); expect_code("R7", 8'h00);
  endtask

  task automatic t_ignore;
    cmd(3'd0, 2'd0, 8'h40);
    issue(3'd0, 2'd0, 8'h90, 1'b1, 1'b1, 1'b1); expect_code("R8", 8'h90);
    issue(3'd1, 2'd0, 8'h12, 1'b1, 1'b1, 1'b0); expect_code("R8", 8'h90);
    cmd(3'd6, 2'd0, 8'h55); expect_code("R8", 8'h90);
    cmd(3'd7, 2'd1, 8'h55); expect_code("R8", 8'h90);
    issue(3'd0, 2'd0, 8'h33, 1'b0, 1'b0, 1'b0); expect_code("R8", 8'h90);
    issue(3'd1, 2'd3, 8'h99, 1'b0, 1'b0, 1'b0);
    cmd(3'd2, 2'd3, 8'h00); expect_code("R8", 8'hEE);
    cmd(3'd2, 2'd0, 8'h00); expect_code("R8", 8'h12);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_set_wiper();
    t_slots();
    t_store();
    t_cmd_step();
    t_strobe();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule